// File: doc/BRIEF.md
# Four-Channel Simultaneous-Sample Conversion Sequencer

This block is the digital controller of a data-acquisition front end that has four track/hold stages sharing one converter. A host writes a four-bit mode word over a chip-select and write-strobe bus. The word sets how many channels are converted, which of two input banks feeds the track/holds, and whether the block is powered down. A rising edge on the start input puts every track/hold into hold. The block then converts channels 0 up to the programmed count, one after another, and stores each 12-bit result in a small result memory. At the end it pulls the interrupt low and returns the track/holds to tracking.

Results are read in order through a pointer that the host cannot set. Each read returns the word under the pointer, and the pointer steps forward when the read ends. A conversion-engine handshake takes the place of the converter. The block pulses a start output, and after a fixed number of clock cycles it captures the engine's result for the channel shown on the channel output. All bus strobes are sampled on the block clock.

Top module: `acq_sequencer`

## Requirements
- R1: After reset, int_n is 1 and hold is 0. data_oe is 0 and bank_sel is 0. With no mode write, a start converts exactly one channel (channel 0) of bank 0.
- R2: A write is active while cs_n and wr_n are both low. The mode word is taken from the last value seen on mode_in during the write, and is captured when either strobe returns high. The word is decoded as follows. Bits [1:0] give the channel count minus one. Bit 2 selects bank 1 when set, and bank_sel shows that bank. Bit 3 requests power-down. The captured mode persists until the next write.
- R3: While cs_n is high, wr_n and rd_n have no effect, and data_oe stays 0.
- R4: A start is a low-to-high transition of conv_n while the block is idle and powered up. On a start, hold goes to 1 at the following clock edge. Channels 0 to count-1 are then converted in ascending order. Each conversion lasts CONV_CYCLES cycles and begins with a one-cycle eng_start pulse. eng_chan shows the channel being converted throughout.
- R5: Rising edges of conv_n while hold is 1 are ignored. The sequence keeps its number of conversions and its length.
- R6: At the clock edge that ends the last conversion, int_n goes low and hold goes low. At all times while hold is 0, eng_chan is 0.
- R7: A read is active while cs_n and rd_n are both low. One cycle after a read begins, data_oe is 1, data_out carries the stored word for the channel under the read pointer, and int_n is 1.
- R8: The read pointer steps to the next channel when a read ends, wrapping from channel 3 to channel 0 whatever the channel count. An accepted start resets it to channel 0.
- R9: While power-down is set, starts are ignored and the bus still accepts writes. A later write with bit 3 clear restores normal operation with the bank and count given in that word.
- R10: A read during a conversion returns the word stored before that sequence began. It advances the read pointer and leaves the results of the sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| conv_n | input | 1 | Conversion start; the rising edge starts a sequence |
| mode_in | input | 4 | Mode word: [1:0] count-1, [2] bank, [3] power-down |
| data_out | output | 12 | Result word under the read pointer |
| data_oe | output | 1 | Result bus drive enable |
| int_n | output | 1 | End-of-sequence interrupt, active low |
| hold | output | 1 | Track/hold control; 1 means hold |
| bank_sel | output | 1 | Input bank routed to the track/holds |
| eng_chan | output | 2 | Channel steered to the converter |
| eng_start | output | 1 | One-cycle conversion start to the engine |
| eng_result | input | 12 | Engine result, captured at the end of each conversion |

## Verification
The hardest case to reach is bus activity that overlaps a running sequence. This covers a read that lands before the first result is written, and a second start pulse that arrives mid-sequence. The bench drives both from inside its conversion-wait loop, timed from the start edge while hold is still high. It then follows the read pointer with its own model, so the words read after the sequence show both that the early read returned the previous word and that the pointer moved. Every bank and count pair is swept, with five reads per sequence so that the pointer wraps.

// File: rtl/acq_sequencer.sv
module acq_sequencer #(
  parameter int DW = 12,
  parameter int NCH = 4,
  parameter int CONV_CYCLES = 32,
  localparam int CW = $clog2(NCH),
  localparam int TW = $clog2(CONV_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          conv_n,
  input  logic [CW+1:0] mode_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          int_n,
  output logic          hold,
  output logic          bank_sel,
  output logic [CW-1:0] eng_chan,
  output logic          eng_start,
  input  logic [DW-1:0] eng_result
);

  logic          wr_q, rd_q, conv_q;
  logic [CW+1:0] mode_lat;
  logic [CW-1:0] cnt_m1, ptr, chan;
  logic          pd, bank;
  logic [TW-1:0] tick;
  logic [DW-1:0] mem [NCH];

  wire wr_act    = !cs_n && !wr_n;
  wire rd_act    = !cs_n && !rd_n;
  wire wr_end    = wr_q && !wr_act;
  wire rd_beg    = rd_act && !rd_q;
  wire rd_end    = rd_q && !rd_act;
  wire start_ok  = !conv_q && conv_n && !hold && !pd;
  wire last_tick = hold && (tick == TW'(CONV_CYCLES - 1));
  wire last_chan = (chan == cnt_m1);
  wire [CW-1:0] ptr_nxt = (ptr == CW'(NCH - 1)) ? '0 : ptr + 1'b1;

  assign bank_sel  = bank;
  assign eng_chan  = chan;
  assign eng_start = hold && (tick == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      conv_q <= 1'b1;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      conv_q <= conv_n;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_lat <= '0;
      cnt_m1 <= '0;
      bank <= 1'b0;
      pd <= 1'b0;
    end else begin
      if (wr_act) mode_lat <= mode_in;
      if (wr_end) begin
        pd <= mode_lat[CW+1];
        if (!mode_lat[CW+1]) begin
          bank <= mode_lat[CW];
          cnt_m1 <= mode_lat[CW-1:0];
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold <= 1'b0;
      chan <= '0;
      tick <= '0;
      ptr <= '0;
      int_n <= 1'b1;
    end else begin
      if (rd_beg) int_n <= 1'b1;
      if (rd_end) ptr <= ptr_nxt;
      if (start_ok) begin
        hold <= 1'b1;
        chan <= '0;
        tick <= '0;
        ptr <= '0;
      end else if (hold) begin
        if (last_tick) begin
          tick <= '0;
          if (last_chan) begin
            hold <= 1'b0;
            chan <= '0;
            int_n <= 1'b0;
          end else begin
            chan <= chan + 1'b1;
          end
        end else begin
          tick <= tick + 1'b1;
        end
      end
    end

  always_ff @(posedge clk)
    if (last_tick) mem[chan] <= eng_result;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      data_oe <= 1'b0;
      data_out <= '0;
    end else begin
      data_oe <= rd_act;
      data_out <= mem[ptr];
    end

endmodule

module acq_sequencer_chk #(
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          wr_n,
  input logic          int_n,
  input logic          hold,
  input logic          eng_start,
  input logic [CW-1:0] eng_chan,
  input logic          data_oe,
  input logic          pd,
  input logic          bank,
  input logic [CW-1:0] cnt_m1
);

  logic wr_seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wr_seen <= 1'b0;
    else wr_seen <= !cs_n && !wr_n;

  // R2
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_seen && !(!cs_n && !wr_n)) |=> $stable({pd, bank, cnt_m1}));

  // R3
  cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !data_oe);

  // R4
  start_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> hold);

  // R6
  int_with_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $fell(hold));

  // R6
  idle_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |-> eng_chan == '0);

  // R9
  pd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pd) |-> !$rose(hold));

endmodule

bind acq_sequencer acq_sequencer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .int_n(int_n),
  .hold(hold), .eng_start(eng_start), .eng_chan(eng_chan),
  .data_oe(data_oe), .pd(pd), .bank(bank), .cnt_m1(cnt_m1)
);

// File: tb/tb_acq_sequencer.sv
`timescale 1ns/100ps
module tb_acq_sequencer;
  localparam int CC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, conv_n = 1'b1;
  logic [3:0] mode_in = '0;
  logic [11:0] data_out, eng_result;
  logic data_oe, int_n, hold, bank_sel, eng_start;
  logic [1:0] eng_chan;
  logic [7:0] tag = '0;

  int checks = 0, errors = 0;
  int mm[4] = '{-1, -1, -1, -1};
  int mptr = 0, m_bank = 0, m_cnt = 1;
  int n_starts = 0, hold_cyc = 0;
  int seen[8];
  bit done = 0;

  always #2.5 clk = ~clk;

  acq_sequencer #(.CONV_CYCLES(CC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .conv_n(conv_n), .mode_in(mode_in), .data_out(data_out),
    .data_oe(data_oe), .int_n(int_n), .hold(hold), .bank_sel(bank_sel),
    .eng_chan(eng_chan), .eng_start(eng_start), .eng_result(eng_result)
  );

  always_comb eng_result = {tag, bank_sel, 1'b1, eng_chan};

  always @(posedge clk) begin
    if (eng_start) begin
      if (n_starts < 8) seen[n_starts] = int'(eng_chan);
      n_starts = n_starts + 1;
    end
    if (hold) hold_cyc = hold_cyc + 1;
  end

  function automatic int expv(int t, int b, int ch);
    return t * 16 + b * 8 + 4 + ch;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [3:0] w, input bit via_cs);
    @(negedge clk); cs_n = 0; wr_n = 0; mode_in = w;
    @(negedge clk);
    if (via_cs) begin cs_n = 1; @(negedge clk); wr_n = 1; end
    else begin wr_n = 1; @(negedge clk); cs_n = 1; end
    mode_in = 4'hF;
    if (!w[3]) begin m_bank = int'(w[2]); m_cnt = int'(w[1:0]) + 1; end
    @(negedge clk);
  endtask

  task automatic rd_word(input string req);
    @(negedge clk); cs_n = 0; rd_n = 0;
    @(posedge clk); #1;
    chk(data_oe == 1'b1, "R7 oe", int'(data_oe), 1);
    chk(int_n == 1'b1, "R7 int cleared", int'(int_n), 1);
    if (mm[mptr] >= 0) chk(int'(data_out) == mm[mptr], req, int'(data_out), mm[mptr]);
    @(negedge clk); rd_n = 1; cs_n = 1;
    mptr = (mptr + 1) % 4;
  endtask

  task automatic convert(input logic [7:0] t, input bit accept, input bit extra, input bit mid_read);
    int int_before;
    int_before = int'(int_n);
    tag = t; n_starts = 0; hold_cyc = 0;
    @(negedge clk); conv_n = 0;
    @(negedge clk); conv_n = 1;
    @(posedge clk); #1;
    chk(hold == accept, accept ? "R4 hold on start" : "R9 start ignored", int'(hold), int'(accept));
    if (accept) begin
      mptr = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (extra && i == 2) conv_n = 0;
        if (extra && i == 3) conv_n = 1;
        if (mid_read && i == 0) rd_word("R10 read during conversion");
        if (!hold) break;
      end
      chk(hold_cyc == m_cnt * CC, "R4 sequence length", hold_cyc, m_cnt * CC);
      chk(n_starts == m_cnt, extra ? "R5 conversions" : "R4 conversions", n_starts, m_cnt);
      for (int k = 0; k < m_cnt && k < 8; k++)
        chk(seen[k] == k, "R4 channel order", seen[k], k);
      chk(int_n == 1'b0, "R6 int low", int'(int_n), 0);
      chk(eng_chan == 2'd0, "R6 steer ch0", int'(eng_chan), 0);
      for (int k = 0; k < m_cnt; k++) mm[k] = expv(int'(t), m_bank, k);
    end else begin
      repeat (4 * CC) @(negedge clk);
      chk(n_starts == 0, "R9 no conversions", n_starts, 0);
      chk(int'(int_n) == int_before, "R9 int unchanged", int'(int_n), int_before);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(int_n == 1'b1, "R1 int reset", int'(int_n), 1);
    chk(hold == 1'b0, "R1 hold reset", int'(hold), 0);
    chk(data_oe == 1'b0, "R1 oe reset", int'(data_oe), 0);
    chk(bank_sel == 1'b0, "R1 bank reset", int'(bank_sel), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    convert(8'd1, 1, 0, 0);
    rd_word("R1 default single channel");

    for (int b = 0; b < 2; b++)
      for (int c = 1; c <= 4; c++) begin
        wr_mode({1'b0, b[0], 2'(c - 1)}, (b + c) % 2 == 1);
        chk(int'(bank_sel) == b, "R2 bank select", int'(bank_sel), b);
        convert(8'(10 + b * 4 + c), 1, 0, 0);
        for (int r = 0; r < 5; r++) rd_word("R8 sequential read");
      end

    wr_mode(4'b0001, 0);
    convert(8'd40, 1, 0, 0);
    rd_word("R2 read ch0");
    @(negedge clk); wr_n = 0; rd_n = 0; mode_in = 4'b0111;
    @(posedge clk); #1;
    chk(data_oe == 1'b0, "R3 oe with cs high", int'(data_oe), 0);
    @(negedge clk); wr_n = 1; rd_n = 1;
    @(negedge clk);
    chk(bank_sel == 1'b0, "R3 write ignored", int'(bank_sel), 0);
    rd_word("R3 pointer unchanged");
    convert(8'd41, 1, 0, 0);
    rd_word("R3 count kept");
    rd_word("R3 count kept ch1");

    wr_mode(4'b0010, 1);
    convert(8'd50, 1, 1, 1);
    for (int r = 0; r < 4; r++) rd_word("R10 results intact");

    wr_mode(4'b1000, 0);
    convert(8'd60, 0, 0, 0);
    rd_word("R9 memory kept");
    wr_mode(4'b0101, 0);
    chk(bank_sel == 1'b1, "R9 wake bank", int'(bank_sel), 1);
    convert(8'd61, 1, 0, 0);
    rd_word("R9 wake ch0");
    rd_word("R9 wake ch1");

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule